// File: doc/BRIEF.md
# Interleaved SEC-DED Pixel Codec

This block protects 16-bit pixel words with a 6-bit single-error-correct, double-error-detect Hamming field and spreads each group of 16 protected words across the link bit by bit. A burst of adjacent bit errors on the serial stream therefore lands as at most one or two flipped bits in any single codeword. The transmit half encodes each accepted pixel into a 22-bit codeword and fills a group buffer. When the group is complete it sends 16 interleaved 22-bit line words on consecutive clocks while the next group fills the second buffer.

The receive half collects 16 line words, restores the codeword order and decodes one word per clock. For every pixel it reports whether a single error was repaired or an error was found that cannot be repaired. The line side is a plain 22-bit word bus. The serialiser and line coding sit outside the block and pass this bus through. The receive side must be fed group-aligned: after reset, the first received word is word 0 of a group.

Top module: `secded_ilv_codec`

## Requirements
- R1: Each codeword has 22 bits. Bit 0 is an even parity bit over the whole codeword, so every codeword has even weight. Hamming check bits sit at positions 1, 2, 4, 8 and 16. Pixel bits 0 to 15 fill positions 3, 5, 6, 7, 9 to 15 and 17 to 21 in ascending order.
- R2: Within a group, line word j bit i is stream bit k = 22*j + i. Stream bit k carries bit floor(k/16) of codeword k mod 16, where codewords are numbered in order of acceptance.
- R3: Line word 0 of a group is presented on the clock after the group's 16th pixel is accepted. The remaining 15 line words follow on consecutive clocks with `line_valid` high.
- R4: With a pixel offered on every clock, groups stream back to back without stalls. Every pixel comes out exactly once and in order.
- R5: With the line looped straight back and pixels offered on every clock, each pixel leaves `px_data` 34 clocks (two groups plus two) after it was accepted.
- R6: A codeword holding one flipped bit, at any position including bit 0, yields the original pixel with `px_corrected`=1 and `px_uncorrectable`=0.
- R7: A codeword holding two flipped bits yields `px_uncorrectable`=1 and `px_corrected`=0.
- R8: Any burst of up to 16 adjacent stream bits within a group is fully corrected, which covers every burst of 11 bits.
- R9: Any burst of up to 31 adjacent stream bits within a group is detected. Words that received two errors report `px_uncorrectable`, and words that received one error are repaired.
- R10: An undisturbed codeword yields the original pixel with both flags 0.
- R11: After reset both valid outputs are low. A partly filled group is discarded, and the next accepted pixel starts a new group.
- R12: Idle clocks between accepted pixels are allowed. A group is sent only once its 16th pixel has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Pixel on `tx_pixel` is accepted this clock |
| tx_pixel | input | 16 | Pixel to protect |
| line_valid | output | 1 | Interleaved line word valid |
| line_word | output | 22 | Interleaved line word toward the link |
| rx_valid | input | 1 | Received line word valid |
| rx_word | input | 22 | Received line word from the link |
| px_valid | output | 1 | Decoded pixel valid |
| px_data | output | 16 | Decoded, corrected pixel |
| px_corrected | output | 1 | One bit of this codeword was repaired |
| px_uncorrectable | output | 1 | Error found that could not be repaired |

## Verification
Two events can fall on the same clock edge in either buffer: the last word of one group is drained, and the 16th word of the next group completes, which swaps the buffers and restarts the drain. The bench provokes this by offering pixels on every clock across three groups. A wrong priority between the two events would drop or repeat a group, or break the 34-clock spacing. The bench judges it by the number of pixels returned, their order and the accept-to-output distance of each pixel. The same runs are repeated with single errors, double errors and bursts injected on the loopback path. Expected flags are derived from how many injected bits fall into each codeword under the stream mapping.

// File: rtl/secded_ilv_pkg.sv
package secded_ilv_pkg;

    localparam int DATA_W   = 16;
    localparam int SYN_W    = 5;
    localparam int CHK_W    = SYN_W + 1;
    localparam int CW_W     = DATA_W + CHK_W;
    localparam int GROUP    = 16;
    localparam int GRP_BITS = CW_W * GROUP;
    localparam int IDX_W    = $clog2(GROUP);

    typedef logic [DATA_W-1:0] px_t;
    typedef logic [CW_W-1:0]   cw_t;

    typedef struct packed {
        px_t  data;
        logic corrected;
        logic uncorrectable;
    } dec_res_t;

    // Payload bits fill the non-power-of-two positions; checks sit at powers of two.
    function automatic cw_t secded_encode(input px_t dt);
        cw_t c;
        int  d;
        c = '0;
        d = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = dt[d];
                d++;
            end
        end
        for (int k = 0; k < SYN_W; k++) begin
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) begin
                    c[1 << k] = c[1 << k] ^ c[p];
                end
            end
        end
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction

    function automatic dec_res_t secded_decode(input cw_t c);
        logic [SYN_W-1:0] s;
        logic             odd;
        cw_t              f;
        dec_res_t         r;
        int               d;
        s = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (c[p]) s = s ^ SYN_W'(p);
        end
        odd             = ^c;
        f               = c;
        r.corrected     = 1'b0;
        r.uncorrectable = 1'b0;
        if (odd) begin
            if (int'(s) < CW_W) begin
                f[s]        = ~f[s];
                r.corrected = 1'b1;
            end else begin
                r.uncorrectable = 1'b1;
            end
        end else if (s != '0) begin
            r.uncorrectable = 1'b1;
        end
        r.data = '0;
        d = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[d] = f[p];
                d++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ilv_pingpong.sv
module ilv_pingpong
    import secded_ilv_pkg::*;
#(
    parameter bit DEINTERLEAVE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  cw_t  in_word,
    output logic out_valid,
    output cw_t  out_word
);

    localparam int LAST = GROUP - 1;

    logic [GRP_BITS-1:0] bank_q [2];
    logic                wr_sel_q, rd_sel_q, draining_q;
    logic [IDX_W-1:0]    wr_cnt_q, rd_cnt_q;
    logic [GRP_BITS-1:0] rd_bits, perm_bits;
    logic                grp_done;

    assign grp_done = in_valid && (wr_cnt_q == IDX_W'(LAST));
    assign rd_bits  = bank_q[rd_sel_q];

    always_ff @(posedge clk) begin
        if (in_valid) begin
            bank_q[wr_sel_q][int'(wr_cnt_q)*CW_W +: CW_W] <= in_word;
        end
    end

    // Bit permutation between row order and column order.
    for (genvar k = 0; k < GRP_BITS; k++) begin : g_perm
        if (DEINTERLEAVE) begin : g_to_rows
            assign perm_bits[k] = rd_bits[(k % CW_W) * GROUP + k / CW_W];
        end else begin : g_to_cols
            assign perm_bits[k] = rd_bits[(k % GROUP) * CW_W + k / GROUP];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sel_q   <= 1'b0;
            rd_sel_q   <= 1'b0;
            draining_q <= 1'b0;
            wr_cnt_q   <= '0;
            rd_cnt_q   <= '0;
            out_valid  <= 1'b0;
            out_word   <= '0;
        end else begin
            out_valid <= draining_q;
            if (draining_q) begin
                out_word <= perm_bits[int'(rd_cnt_q)*CW_W +: CW_W];
                rd_cnt_q <= (rd_cnt_q == IDX_W'(LAST)) ? '0 : rd_cnt_q + 1'b1;
                if (rd_cnt_q == IDX_W'(LAST)) draining_q <= 1'b0;
            end
            if (in_valid) begin
                wr_cnt_q <= (wr_cnt_q == IDX_W'(LAST)) ? '0 : wr_cnt_q + 1'b1;
            end
            // Completion of a new group outranks the end of the previous drain.
            if (grp_done) begin
                wr_sel_q   <= ~wr_sel_q;
                rd_sel_q   <= wr_sel_q;
                draining_q <= 1'b1;
                rd_cnt_q   <= '0;
            end
        end
    end

    logic [IDX_W-1:0] emit_cnt_q;
    always_ff @(posedge clk) begin
        if (rst) emit_cnt_q <= '0;
        else if (out_valid) emit_cnt_q <= emit_cnt_q + 1'b1;
    end

    // R3
    drain_start_chk: assert property (@(posedge clk) disable iff (rst)
        grp_done |-> ##2 out_valid);

    // R3
    whole_group_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> emit_cnt_q == '0);

    // R4
    bank_split_chk: assert property (@(posedge clk) disable iff (rst)
        draining_q |-> (wr_sel_q != rd_sel_q));

endmodule

// File: rtl/secded_dec_stage.sv
module secded_dec_stage
    import secded_ilv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  cw_t  in_word,
    output logic px_valid,
    output px_t  px_data,
    output logic px_corrected,
    output logic px_uncorrectable
);

    dec_res_t res;
    assign res = secded_decode(in_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            px_valid         <= 1'b0;
            px_data          <= '0;
            px_corrected     <= 1'b0;
            px_uncorrectable <= 1'b0;
        end else begin
            px_valid <= in_valid;
            if (in_valid) begin
                {px_data, px_corrected, px_uncorrectable} <= res;
            end else begin
                px_corrected     <= 1'b0;
                px_uncorrectable <= 1'b0;
            end
        end
    end

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(px_corrected && px_uncorrectable));

    // R10
    flag_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (px_corrected || px_uncorrectable) |-> px_valid);

    // R5
    stage_delay_chk: assert property (@(posedge clk) disable iff (rst)
        px_valid |-> $past(in_valid));

endmodule

// File: rtl/secded_ilv_codec.sv
module secded_ilv_codec
    import secded_ilv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_pixel,
    output logic              line_valid,
    output logic [CW_W-1:0]   line_word,
    input  logic              rx_valid,
    input  logic [CW_W-1:0]   rx_word,
    output logic              px_valid,
    output logic [DATA_W-1:0] px_data,
    output logic              px_corrected,
    output logic              px_uncorrectable
);

    cw_t tx_cw;
    cw_t dil_word;
    logic dil_valid;

    assign tx_cw = secded_encode(tx_pixel);

    ilv_pingpong #(.DEINTERLEAVE(1'b0)) u_ilv (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_valid),
        .in_word   (tx_cw),
        .out_valid (line_valid),
        .out_word  (line_word)
    );

    ilv_pingpong #(.DEINTERLEAVE(1'b1)) u_dil (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid),
        .in_word   (rx_word),
        .out_valid (dil_valid),
        .out_word  (dil_word)
    );

    secded_dec_stage u_dec (
        .clk              (clk),
        .rst              (rst),
        .in_valid         (dil_valid),
        .in_word          (dil_word),
        .px_valid         (px_valid),
        .px_data          (px_data),
        .px_corrected     (px_corrected),
        .px_uncorrectable (px_uncorrectable)
    );

    // R1
    tx_parity_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (^tx_cw) == 1'b0);

endmodule

// File: tb/secded_ilv_codec_tb.sv
module secded_ilv_codec_tb;
    import secded_ilv_pkg::*;

    localparam int CLK_P = 10;
    localparam int LAT   = 2 * GROUP + 2;
    localparam int MAXG  = 4;
    localparam int MAXW  = MAXG * GROUP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0;
    px_t  tx_pixel = '0;
    logic line_valid, rx_valid, px_valid, px_corrected, px_uncorrectable;
    cw_t  line_word, rx_word;
    px_t  px_data;

    always #(CLK_P/2) clk = ~clk;

    int nvec = 0, nerr = 0;
    int ecnt = 0;
    int lc = 0, oc = 0, cur_line = 0;
    px_t  px_in    [MAXW];
    int   acc_t    [MAXW];
    cw_t  inj      [MAXW];
    cw_t  line_rec [MAXW];
    int   line_t   [MAXW];
    px_t  o_data   [MAXW];
    logic o_c      [MAXW];
    logic o_u      [MAXW];
    int   o_t      [MAXW];

    assign rx_valid = line_valid;
    assign rx_word  = line_word ^ inj[cur_line];

    secded_ilv_codec u_dut (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_pixel(tx_pixel),
        .line_valid(line_valid), .line_word(line_word),
        .rx_valid(rx_valid), .rx_word(rx_word),
        .px_valid(px_valid), .px_data(px_data),
        .px_corrected(px_corrected), .px_uncorrectable(px_uncorrectable)
    );

    always @(posedge clk) ecnt = ecnt + 1;

    always @(negedge clk) begin
        if (!rst && line_valid && lc < MAXW) begin
            cur_line     = lc;
            line_rec[lc] = line_word;
            line_t[lc]   = ecnt;
            lc++;
        end
        if (!rst && px_valid && oc < MAXW) begin
            o_data[oc] = px_data;
            o_c[oc]    = px_corrected;
            o_u[oc]    = px_uncorrectable;
            o_t[oc]    = ecnt;
            oc++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    always @(posedge clk) begin
        if (ecnt > 100000) begin
            nerr++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected under 100000", ecnt);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic clear_inj();
        for (int n = 0; n < MAXW; n++) inj[n] = '0;
    endtask

    task automatic fill(input int seed);
        for (int n = 0; n < MAXW; n++) px_in[n] = px_t'((n * 32'h1F35) ^ seed ^ (n << 9));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tx_valid = 1'b0;
        lc = 0; oc = 0; cur_line = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Flip stream bits [start, start+len) of group g (R2 mapping).
    task automatic burst(input int g, input int start, input int len);
        for (int k = start; k < start + len; k++) begin
            inj[g*GROUP + k / CW_W][k % CW_W] = 1'b1;
        end
    endtask

    function automatic int errs_in(input int g, input int w);
        int c = 0;
        for (int j = 0; j < GROUP; j++)
            for (int i = 0; i < CW_W; i++)
                if (inj[g*GROUP + j][i] && ((j*CW_W + i) % GROUP) == w) c++;
        return c;
    endfunction

    task automatic run_groups(input int ng, input int gap, input bit do_rst);
        if (do_rst) do_reset();
        for (int n = 0; n < ng * GROUP; n++) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_pixel = px_in[n];
            acc_t[n] = ecnt;
            if (gap > 0 && (n % 3) == 1) begin
                for (int q = 0; q < gap; q++) begin
                    @(negedge clk);
                    tx_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        tx_valid = 1'b0;
        for (int t = 0; t < 4 * LAT && oc < ng * GROUP; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Per-word comparison against error counts from the injection map.
    task automatic judge(input int ng);
        check(oc == ng * GROUP, "R4 pixel count", oc, ng * GROUP);
        for (int n = 0; n < ng * GROUP && n < oc; n++) begin
            int e;
            e = errs_in(n / GROUP, n % GROUP);
            if (e == 0) begin
                check(o_data[n] == px_in[n] && !o_c[n] && !o_u[n],
                      "R10 clean word", {o_data[n], o_c[n], o_u[n]}, {px_in[n], 2'b00});
            end else if (e == 1) begin
                check(o_data[n] == px_in[n] && o_c[n] && !o_u[n],
                      "R6 single error repaired", {o_data[n], o_c[n], o_u[n]}, {px_in[n], 2'b10});
            end else begin
                check(!o_c[n] && o_u[n], "R7 double error flagged",
                      {o_c[n], o_u[n]}, 2'b01);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!line_valid && !px_valid, "R11 outputs idle in reset", {line_valid, px_valid}, 0);
        do_reset();
        fill(32'h0A5C);
        for (int n = 0; n < 7; n++) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_pixel = px_t'(16'hDEAD + n);
        end
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!line_valid, "R11 partial group not sent", line_valid, 0);
        clear_inj();
        run_groups(1, 0, 1'b1);
        judge(1);
    endtask

    task automatic t_clean();
        clear_inj();
        fill(32'h3C71);
        px_in[0] = 16'h0000;
        px_in[1] = 16'hFFFF;
        for (int n = 0; n < GROUP; n++) px_in[32 + n] = px_t'(1 << n);
        run_groups(3, 0, 1'b1);
        judge(3);
        for (int n = 0; n < 3 * GROUP && n < oc; n++) begin
            check(o_t[n] - acc_t[n] == LAT + 1, "R5 fixed latency", o_t[n] - acc_t[n], LAT + 1);
        end
        for (int g = 0; g < 3; g++) begin
            check(line_t[g*GROUP] == acc_t[g*GROUP + GROUP - 1] + 2, "R3 group start timing",
                  line_t[g*GROUP], acc_t[g*GROUP + GROUP - 1] + 2);
            check(line_t[g*GROUP + GROUP - 1] == line_t[g*GROUP] + GROUP - 1,
                  "R3 consecutive line words", line_t[g*GROUP + GROUP - 1], line_t[g*GROUP] + GROUP - 1);
            for (int w = 0; w < GROUP; w++) begin
                cw_t c;
                px_t d;
                int  di;
                for (int b = 0; b < CW_W; b++) begin
                    int k;
                    k = b * GROUP + w;
                    c[b] = line_rec[g*GROUP + k / CW_W][k % CW_W];
                end
                d = '0;
                di = 0;
                for (int p = 1; p < CW_W; p++) begin
                    if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                        d[di] = c[p];
                        di++;
                    end
                end
                check((^c) == 1'b0, "R1 even codeword weight", ^c, 0);
                check(d == px_in[g*GROUP + w], "R2 payload placement after interleave",
                      d, px_in[g*GROUP + w]);
            end
        end
    endtask

    task automatic t_single();
        clear_inj();
        fill(32'h7713);
        inj[0][0]   = 1'b1;
        inj[3][5]   = 1'b1;
        inj[15][21] = 1'b1;
        inj[8][10]  = 1'b1;
        inj[16 + 2][1] = 1'b1;
        run_groups(2, 0, 1'b1);
        // R6 words hit: group0 w0 (parity bit), w7, w15, w10; group1 w13
        judge(2);
    endtask

    task automatic t_double();
        clear_inj();
        fill(32'h51E9);
        inj[0][3]   = 1'b1;
        inj[7][9]   = 1'b1;
        inj[0][9]   = 1'b1;
        inj[15][15] = 1'b1;
        inj[0][5]   = 1'b1;
        run_groups(2, 0, 1'b1);
        // R7 words 3 and 9 of group 0 carry two errors each
        judge(2);
    endtask

    task automatic t_burst_fix();
        clear_inj();
        fill(32'h2468);
        burst(0, 100, 11);
        burst(1, 336, 16);
        run_groups(2, 0, 1'b1);
        // R8 bursts of 11 and 16 adjacent bits give one error per word at most
        judge(2);
    endtask

    task automatic t_burst_detect();
        clear_inj();
        fill(32'h9BD1);
        burst(0, 200, 31);
        run_groups(2, 0, 1'b1);
        // R9 fifteen words receive two errors, one word receives one
        judge(2);
    endtask

    task automatic t_gaps();
        clear_inj();
        fill(32'hC0DE);
        run_groups(2, 2, 1'b1);
        judge(2);
        for (int g = 0; g < 2; g++) begin
            check(line_t[g*GROUP] == acc_t[g*GROUP + GROUP - 1] + 2, "R12 send only after 16th pixel",
                  line_t[g*GROUP], acc_t[g*GROUP + GROUP - 1] + 2);
        end
    endtask

    initial begin
        clear_inj();
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_burst_fix();
        t_burst_detect();
        t_gaps();
        summary();
        $finish;
    end

endmodule